// File: doc/BRIEF.md
# NOR Flash Status-Polling Erase/Program Sequencer

This block drives a NOR flash device that reports progress through a readable status byte. A single start request picks one of two operations: erasing the block that contains a given byte offset, or programming one byte at a given offset. The sequencer first returns the device to read-array mode. It then issues a two-write command at the target offset and reads the status byte at that offset until the device reports ready. If the device does not become ready within a caller-supplied number of clock cycles, the operation ends with an error.

The flash side is a simple single-cycle bus. A write strobe carries an address and a data byte. A read strobe carries an address, and the device returns its byte exactly one cycle later. On the request side, the caller supplies the operation, offset, data byte and timeout together with a start pulse. The caller then waits for a one-cycle completion pulse, which comes with an error flag and the last status byte read from the device.

Top module: `nor_sr_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, fl_we_o and fl_re_o are all low.
- R2: Every accepted operation begins with a write of 0xFF to address 0.
- R3: With op_i = 0 (block erase), the next two writes are 0x20 and then 0xD0, both to the target offset.
- R4: With op_i = 1 (byte program), the next two writes are 0x40 and then the data byte, both to the target offset.
- R5: After the command, the status byte is read at the target offset, one read every two cycles, until a read returns bit 7 set. Bits 6:0 are disregarded while bit 7 is clear.
- R6: A read with bit 7 set and any of bits 6:0 set ends the operation with err_o high, and no further bus write follows.
- R7: A poll cycle counter is 0 in the cycle of the first read and advances by one each cycle, so the response to read k is judged at count 2k-1. After a read with bit 7 clear whose count exceeds timeout_i, the operation ends with err_o high. A never-ready device therefore sees exactly (timeout_i+1)/2+1 reads (integer division).
- R8: A read returning exactly 0x80 (bit 7 set, bits 6:0 clear) is followed by a write of 0xFF to address 0, and done_o rises in the next cycle with err_o low.
- R9: status_o shows the final status byte read, from the done cycle until the next accepted start.
- R10: done_o is high for exactly one cycle per operation. err_o is valid in that cycle and holds until the next accepted start.
- R11: busy_o is high from the cycle after an accepted start through the done cycle. A start_i pulse while busy_o is high is ignored.
- R12: fl_we_o and fl_re_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| op_i | input | 1 | 0 = block erase, 1 = byte program |
| offset_i | input | ADDR_W | Target byte offset |
| data_i | input | 8 | Byte to program |
| timeout_i | input | TMO_W | Poll timeout in clock cycles |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Failure flag, valid with done_o |
| status_o | output | 8 | Last status byte read |
| fl_addr_o | output | ADDR_W | Flash bus address |
| fl_wdata_o | output | 8 | Flash bus write data |
| fl_we_o | output | 1 | Flash bus write strobe |
| fl_re_o | output | 1 | Flash bus read strobe |
| fl_rdata_i | input | 8 | Flash read data, one cycle after fl_re_o |

## Verification
A device model logs every bus write and counts status reads. Erase and program runs with different offsets and data show that the command pairs depend on op_i and carry the right operands. Status sequences cover several cases: busy reads with stray low bits, a clean ready, and ready with a fault bit. These separate the ignored bits from a real hardware failure, and show whether the closing reset write is issued or skipped. Never-ready devices with timeouts of 0 and 6 pin down the exact read count. A ready that arrives on the read whose count equals the timeout shows that the comparison is strictly greater-than. A start pulse in mid-operation with a different opcode and offset must leave the write log unchanged.

// File: rtl/nor_sr_seq_pkg.sv
package nor_sr_seq_pkg;
  localparam int FL_DATA_W = 8;
  localparam int RDY_BIT   = FL_DATA_W - 1;

  localparam logic [FL_DATA_W-1:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [FL_DATA_W-1:0] CMD_ERASE_SET  = 8'h20;
  localparam logic [FL_DATA_W-1:0] CMD_ERASE_GO   = 8'hD0;
  localparam logic [FL_DATA_W-1:0] CMD_PROG_SET   = 8'h40;

  typedef enum logic {
    OP_ERASE   = 1'b0,
    OP_PROGRAM = 1'b1
  } seq_op_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RESET  = 3'd1,
    ST_CMD    = 3'd2,
    ST_ARG    = 3'd3,
    ST_POLL   = 3'd4,
    ST_SAMPLE = 3'd5,
    ST_CLOSE  = 3'd6,
    ST_FINISH = 3'd7
  } seq_state_t;
endpackage

// File: rtl/nor_sr_seq_eval.sv
module nor_sr_seq_eval
  import nor_sr_seq_pkg::*;
(
  input  logic [FL_DATA_W-1:0] status_i,
  output logic                 ready_o,
  output logic                 fault_o
);
  always_comb begin
    ready_o = status_i[RDY_BIT];
    fault_o = |status_i[RDY_BIT-1:0];
  end
endmodule

// File: rtl/nor_sr_seq_timer.sv
module nor_sr_seq_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  localparam int CNT_W = TMO_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | en_i;
    cnt_d  = cnt_q;
    if (clr_i)                 cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = cnt_q > {1'b0, limit_i};
endmodule

// File: rtl/nor_sr_seq_ctrl.sv
module nor_sr_seq_ctrl
  import nor_sr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       ready_i,
  input  logic       fault_i,
  input  logic       expired_i,
  output seq_state_t state_o,
  output logic       accept_o,
  output logic       fail_o,
  output logic       sample_o,
  output logic       tmr_clr_o,
  output logic       tmr_en_o
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_RESET;
      ST_RESET:  state_d = ST_CMD;
      ST_CMD:    state_d = ST_ARG;
      ST_ARG:    state_d = ST_POLL;
      ST_POLL:   state_d = ST_SAMPLE;
      ST_SAMPLE: begin
        if (ready_i)        state_d = fault_i ? ST_FINISH : ST_CLOSE;
        else if (expired_i) state_d = ST_FINISH;
        else                state_d = ST_POLL;
      end
      ST_CLOSE:  state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_o   = state_q;
    accept_o  = (state_q == ST_IDLE) && start_i;
    sample_o  = (state_q == ST_SAMPLE);
    fail_o    = sample_o && ((ready_i && fault_i) || (!ready_i && expired_i));
    tmr_clr_o = (state_q == ST_ARG);
    tmr_en_o  = (state_q == ST_POLL) || (state_q == ST_SAMPLE);
  end
endmodule

// File: rtl/nor_sr_seq_busdrv.sv
module nor_sr_seq_busdrv
  import nor_sr_seq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  seq_state_t           state_i,
  input  seq_op_t              op_i,
  input  logic [ADDR_W-1:0]    offset_i,
  input  logic [FL_DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [FL_DATA_W-1:0] wdata_o,
  output logic                 we_o,
  output logic                 re_o
);
  always_comb begin
    addr_o  = '0;
    wdata_o = '0;
    we_o    = 1'b0;
    re_o    = 1'b0;
    unique case (state_i)
      ST_RESET, ST_CLOSE: begin
        we_o    = 1'b1;
        wdata_o = CMD_READ_ARRAY;
      end
      ST_CMD: begin
        we_o    = 1'b1;
        addr_o  = offset_i;
        wdata_o = (op_i == OP_PROGRAM) ? CMD_PROG_SET : CMD_ERASE_SET;
      end
      ST_ARG: begin
        we_o    = 1'b1;
        addr_o  = offset_i;
        wdata_o = (op_i == OP_PROGRAM) ? data_i : CMD_ERASE_GO;
      end
      ST_POLL: begin
        re_o   = 1'b1;
        addr_o = offset_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nor_sr_seq.sv
module nor_sr_seq
  import nor_sr_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int TMO_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 op_i,
  input  logic [ADDR_W-1:0]    offset_i,
  input  logic [FL_DATA_W-1:0] data_i,
  input  logic [TMO_W-1:0]     timeout_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic [FL_DATA_W-1:0] status_o,
  output logic [ADDR_W-1:0]    fl_addr_o,
  output logic [FL_DATA_W-1:0] fl_wdata_o,
  output logic                 fl_we_o,
  output logic                 fl_re_o,
  input  logic [FL_DATA_W-1:0] fl_rdata_i
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_state_t state;
  logic accept, fail, sample, tmr_clr, tmr_en;
  logic ready, fault, expired;

  seq_op_t              op_q;
  logic [ADDR_W-1:0]    offs_q;
  logic [FL_DATA_W-1:0] data_q;
  logic [TMO_W-1:0]     tmo_q;
  logic [FL_DATA_W-1:0] stat_q;
  logic                 err_q, err_d, err_en;

  nor_sr_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_i),
    .ready_i   (ready),
    .fault_i   (fault),
    .expired_i (expired),
    .state_o   (state),
    .accept_o  (accept),
    .fail_o    (fail),
    .sample_o  (sample),
    .tmr_clr_o (tmr_clr),
    .tmr_en_o  (tmr_en)
  );

  nor_sr_seq_eval u_eval (
    .status_i (fl_rdata_i),
    .ready_o  (ready),
    .fault_o  (fault)
  );

  nor_sr_seq_timer #(.TMO_W(TMO_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (tmr_clr),
    .en_i      (tmr_en),
    .limit_i   (tmo_q),
    .expired_o (expired)
  );

  nor_sr_seq_busdrv #(.ADDR_W(ADDR_W)) u_bus (
    .state_i  (state),
    .op_i     (op_q),
    .offset_i (offs_q),
    .data_i   (data_q),
    .addr_o   (fl_addr_o),
    .wdata_o  (fl_wdata_o),
    .we_o     (fl_we_o),
    .re_o     (fl_re_o)
  );

  // Request operands, loaded only when a start is accepted
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      op_q   <= OP_ERASE;
      offs_q <= '0;
      data_q <= '0;
      tmo_q  <= '0;
    end else if (accept) begin
      op_q   <= seq_op_t'(op_i);
      offs_q <= offset_i;
      data_q <= data_i;
      tmo_q  <= timeout_i;
    end
  end

  // Status capture on every sampled read
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  stat_q <= '0;
    else if (sample) stat_q <= fl_rdata_i;
  end

  always_comb begin
    err_en = accept | fail;
    err_d  = fail;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign busy_o   = (state != ST_IDLE);
  assign done_o   = (state == ST_FINISH);
  assign err_o    = err_q;
  assign status_o = stat_q;
endmodule

// File: rtl/nor_sr_seq_checker.sv
module nor_sr_seq_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [7:0]        status_o,
  input logic [ADDR_W-1:0] fl_addr_o,
  input logic [7:0]        fl_wdata_o,
  input logic              fl_we_o,
  input logic              fl_re_o
);
  assert_bus_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we_o && fl_re_o));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  assert_opening_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (fl_we_o && fl_addr_o == '0 && fl_wdata_o == 8'hFF));

  assert_closing_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> ($past(fl_we_o) && $past(fl_addr_o) == '0 && $past(fl_wdata_o) == 8'hFF));

  assert_fault_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o && status_o[7]) |-> (status_o[6:0] != 7'd0));
endmodule

bind nor_sr_seq nor_sr_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .status_o   (status_o),
  .fl_addr_o  (fl_addr_o),
  .fl_wdata_o (fl_wdata_o),
  .fl_we_o    (fl_we_o),
  .fl_re_o    (fl_re_o)
);

// File: tb/nor_sr_seq_test.sv
module nor_sr_seq_test;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 24;
  localparam int TMO_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic              op_i;
  logic [ADDR_W-1:0] offset_i;
  logic [7:0]        data_i;
  logic [TMO_W-1:0]  timeout_i;
  logic              busy_o, done_o, err_o;
  logic [7:0]        status_o;
  logic [ADDR_W-1:0] fl_addr_o;
  logic [7:0]        fl_wdata_o;
  logic              fl_we_o, fl_re_o;
  logic [7:0]        fl_rdata;

  always #(CLK_P/2) clk = ~clk;

  nor_sr_seq #(.ADDR_W(ADDR_W), .TMO_W(TMO_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .offset_i(offset_i), .data_i(data_i), .timeout_i(timeout_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .status_o(status_o),
    .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .fl_we_o(fl_we_o),
    .fl_re_o(fl_re_o), .fl_rdata_i(fl_rdata)
  );

  // Device model: logs writes, answers reads one cycle later
  int                mdl_busy_n;
  logic [7:0]        mdl_busy_val, mdl_final_val;
  logic [ADDR_W-1:0] mdl_rd_addr;
  logic              mdl_clr;
  int                wr_n, rd_n, bad_rd;
  logic [ADDR_W-1:0] wr_addr [16];
  logic [7:0]        wr_data [16];

  always @(posedge clk) begin
    if (mdl_clr) begin
      wr_n <= 0; rd_n <= 0; bad_rd <= 0; fl_rdata <= 8'h00;
    end else begin
      if (fl_we_o) begin
        if (wr_n < 16) begin
          wr_addr[wr_n] <= fl_addr_o;
          wr_data[wr_n] <= fl_wdata_o;
        end
        wr_n <= wr_n + 1;
      end
      if (fl_re_o) begin
        fl_rdata <= (rd_n < mdl_busy_n) ? mdl_busy_val : mdl_final_val;
        rd_n     <= rd_n + 1;
        if (fl_addr_o != mdl_rd_addr) bad_rd <= bad_rd + 1;
      end
    end
  end

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  bit   r_done_ok, r_pulse_ok, r_busy_ok;
  logic r_err;
  logic [7:0] r_stat;

  task automatic run_op(input bit op, input logic [ADDR_W-1:0] off,
                        input logic [7:0] dat, input int tmo, input int nbusy,
                        input logic [7:0] fin, input bit poke);
    int cyc;
    mdl_busy_n    = nbusy;
    mdl_busy_val  = 8'h6F;
    mdl_final_val = fin;
    mdl_rd_addr   = off;
    @(negedge clk); mdl_clr = 1'b1;
    @(negedge clk); mdl_clr = 1'b0;
    start_i = 1'b1; op_i = op; offset_i = off; data_i = dat;
    timeout_i = TMO_W'(tmo);
    @(negedge clk);
    start_i = 1'b0;
    r_busy_ok = busy_o;
    cyc = 0;
    r_done_ok = 1'b0;
    while (cyc < 1000) begin
      if (done_o) begin r_done_ok = 1'b1; break; end
      if (poke && cyc == 2) begin
        start_i = 1'b1; op_i = ~op; offset_i = off ^ 24'h000F00; data_i = ~dat;
      end else start_i = 1'b0;
      if (!busy_o) r_busy_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    r_err  = err_o;
    r_stat = status_o;
    @(negedge clk);
    r_pulse_ok = !done_o;
  endtask

  task automatic chk_writes(input string req, input int n,
                            input logic [ADDR_W-1:0] a1, input logic [7:0] d1,
                            input logic [ADDR_W-1:0] a2, input logic [7:0] d2);
    chk(wr_n == n, req, "write count", wr_n, n);
    chk(wr_addr[0] == '0 && wr_data[0] == 8'hFF, "R2", "opening write", wr_data[0], 8'hFF);
    chk(wr_addr[1] == a1 && wr_data[1] == d1, req, "first command write", wr_data[1], d1);
    chk(wr_addr[2] == a2 && wr_data[2] == d2, req, "second command write", wr_data[2], d2);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start_i = 1'b0; op_i = 1'b0; offset_i = '0; data_i = '0;
    timeout_i = '0; mdl_clr = 1'b1; mdl_busy_n = 0;
    mdl_busy_val = 8'h00; mdl_final_val = 8'h80; mdl_rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !fl_we_o && !fl_re_o, "R1", "idle outputs",
        {busy_o, done_o, err_o, fl_we_o, fl_re_o}, 0);
  endtask

  task automatic t_erase_ok;
    run_op(1'b0, 24'h012340, 8'h00, 100, 3, 8'h80, 1'b0);
    chk(r_done_ok, "R10", "erase done seen", r_done_ok, 1);
    chk_writes("R3", 4, 24'h012340, 8'h20, 24'h012340, 8'hD0);
    chk(wr_addr[3] == '0 && wr_data[3] == 8'hFF, "R8", "closing write", wr_data[3], 8'hFF);
    chk(rd_n == 4 && bad_rd == 0, "R5", "poll reads at offset", rd_n, 4);
    chk(r_err == 1'b0, "R8", "erase error flag", r_err, 0);
    chk(r_stat == 8'h80, "R9", "erase status", r_stat, 8'h80);
    chk(r_pulse_ok, "R10", "done one cycle", !r_pulse_ok, 0);
    chk(r_busy_ok, "R11", "busy through op", r_busy_ok, 1);
  endtask

  task automatic t_program_ok;
    run_op(1'b1, 24'h00ABCD, 8'h5A, 50, 0, 8'h80, 1'b0);
    chk_writes("R4", 4, 24'h00ABCD, 8'h40, 24'h00ABCD, 8'h5A);
    chk(rd_n == 1 && bad_rd == 0, "R5", "single ready read", rd_n, 1);
    chk(r_err == 1'b0 && r_stat == 8'h80, "R8", "program ok", {r_err, r_stat}, 8'h80);
  endtask

  task automatic t_fault;
    run_op(1'b1, 24'h000100, 8'hC3, 100, 2, 8'h90, 1'b0);
    chk(r_err == 1'b1, "R6", "fault error flag", r_err, 1);
    chk(wr_n == 3, "R6", "no closing write", wr_n, 3);
    chk(r_stat == 8'h90, "R9", "fault status", r_stat, 8'h90);
    repeat (3) @(negedge clk);
    chk(err_o == 1'b1 && status_o == 8'h90, "R10", "err and status held",
        {err_o, status_o}, 9'h190);
  endtask

  task automatic t_timeout(input int tmo);
    int exp_n;
    exp_n = (tmo + 1) / 2 + 1;
    run_op(1'b0, 24'h002000, 8'h00, tmo, 1000, 8'h80, 1'b0);
    chk(r_err == 1'b1, "R7", "timeout error flag", r_err, 1);
    chk(rd_n == exp_n, "R7", "reads before timeout", rd_n, exp_n);
    chk(wr_n == 3, "R7", "no closing write", wr_n, 3);
    chk(r_stat == 8'h6F, "R9", "timeout status", r_stat, 8'h6F);
  endtask

  task automatic t_boundary;
    // read 3 busy at count 5 == timeout: not expired, read 4 is ready
    run_op(1'b0, 24'h004000, 8'h00, 5, 3, 8'h80, 1'b0);
    chk(r_err == 1'b0, "R7", "count equal to timeout passes", r_err, 0);
    chk(rd_n == 4, "R5", "busy bits ignored until ready", rd_n, 4);
  endtask

  task automatic t_start_ignored;
    run_op(1'b0, 24'h00A000, 8'h11, 100, 2, 8'h80, 1'b1);
    chk_writes("R11", 4, 24'h00A000, 8'h20, 24'h00A000, 8'hD0);
    chk(bad_rd == 0 && rd_n == 3, "R11", "reads unaffected by start", rd_n, 3);
    repeat (4) @(negedge clk);
    chk(!busy_o && wr_n == 4, "R11", "no second operation", wr_n, 4);
  endtask

  task automatic t_bus_exclusive;
    bit clash = 0;
    mdl_busy_n = 2; mdl_final_val = 8'h80; mdl_rd_addr = 24'h000050;
    @(negedge clk);
    start_i = 1'b1; op_i = 1'b1; offset_i = 24'h000050; data_i = 8'hA5; timeout_i = 16'd40;
    @(negedge clk); start_i = 1'b0;
    repeat (20) begin
      if (fl_we_o && fl_re_o) clash = 1;
      @(negedge clk);
    end
    chk(!clash, "R12", "strobes exclusive", clash, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_erase_ok();
    t_program_ok();
    t_fault();
    t_timeout(6);
    t_timeout(0);
    t_boundary();
    t_start_ignored();
    t_bus_exclusive();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule